// File: doc/BRIEF.md
# USB Host Wrapper Control and Interrupt Register Bank

This block is a 32-bit control and status register bank that sits beside a USB 2.0 host controller. A simple word-only register bus (request, write enable, byte address, write data) reaches it, and it returns read data and an error flag one cycle after each request. The bank holds the wrapper configuration and drives it out as ports: bus filter bypass, port strap bits, frame-length adjust, endianness select, coherency select and bus-master enable. It also holds a scratch word and a slave-error enable bit.

A two-source interrupt unit collects hardware events into sticky status bits. Software clears them by writing ones. The mask can be changed only through a write-one-to-unmask register and a write-one-to-mask register, and it comes out of reset fully masked. One level interrupt line is high while any unmasked status bit is set.

Top module: `usb_ctrl_csr`

## Requirements
- R1: After reset, reads return 0x20 at 0x38, 1 at 0x48 and 0x3 at 0x68, and zero at every other mapped offset. `frame_adj_o` is 0x20, `bus_master_en_o` is 1, the other configuration outputs are 0 and `irq_o` is low.
- R2: Writes to the configuration words store only their defined field, and reserved bits read back as zero. The fields are: 0x30 bits [3:0] `byp_o`; 0x34 bits [4:0] `port_o`; 0x38 bits [5:0] `frame_adj_o`; 0x40 bit 0 `big_endian_o`; 0x44 bit 0 `coherent_o`; 0x48 bit 0 `bus_master_en_o`; 0x60 bit 0 slave-error enable. Each output takes its new value at the clock edge that accepts the write.
- R3: `rdata_o` and `err_o` answer a request in the cycle after it. `rdata_o` is zero in every cycle that does not follow a read request.
- R4: The mask word at 0x68 (bit 0 = source 0, bit 1 = source 1, 1 = masked) is read-only: a bus write to it changes nothing.
- R5: Writing ones to 0x6C clears the matching mask bits. Writing ones to 0x70 sets them. Both offsets read as zero.
- R6: Status at 0x64 (bit 0 = source 0 from `evt_i[0]`, bit 1 = source 1 from `evt_i[1]`) becomes 1 at the edge after an event and stays set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq_o` is high exactly when some status bit is 1 while its mask bit is 0. It follows the stored state without added delay.
- R9: Reads of unmapped or misaligned offsets return zero, and writes to them change no register.
- R10: When the slave-error enable is 1, any access to an unmapped or misaligned offset raises `err_o` in the response cycle. Mapped accesses, and all accesses while the enable is 0, leave `err_o` low.
- R11: Offset 0x78 is a 32-bit read/write scratch word that resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | Error response, one cycle after the request |
| evt_i | input | 2 | Interrupt source events, one bit per source |
| byp_o | output | 4 | Bus filter bypass field |
| port_o | output | 5 | Port strap bits |
| frame_adj_o | output | 6 | Frame-length adjust value |
| big_endian_o | output | 1 | Endianness select |
| coherent_o | output | 1 | Coherent path select |
| bus_master_en_o | output | 1 | Bus-master enable |
| irq_o | output | 1 | Level interrupt |

## Verification
A write or an event is taken at one rising edge. The configuration outputs, the status and mask state and `irq_o` all show the result directly after that edge, so the bench reads those ports at the following falling edge. A read or any other access gives its `rdata_o` and `err_o` one cycle later. The driver queues the expected response for every access, and a monitor compares it 2 ns after the edge that registers the response. Each access is followed by an idle cycle, so a response can never be matched against the wrong request.

// File: rtl/usb_ctrl_csr_pkg.sv
package usb_ctrl_csr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_REGS = 12;
  localparam int unsigned NUM_SRC  = 2;
  localparam int unsigned BYP_W    = 4;
  localparam int unsigned PORT_W   = 5;
  localparam int unsigned FADJ_W   = 6;
  localparam logic [FADJ_W-1:0] FADJ_RST = 6'h20;

  localparam int unsigned IDX_BYP   = 0;
  localparam int unsigned IDX_PORT  = 1;
  localparam int unsigned IDX_FADJ  = 2;
  localparam int unsigned IDX_END   = 3;
  localparam int unsigned IDX_COH   = 4;
  localparam int unsigned IDX_BME   = 5;
  localparam int unsigned IDX_CTRL  = 6;
  localparam int unsigned IDX_ISTAT = 7;
  localparam int unsigned IDX_IMASK = 8;
  localparam int unsigned IDX_IEN   = 9;
  localparam int unsigned IDX_IDIS  = 10;
  localparam int unsigned IDX_SCR   = 11;

  function automatic logic [7:0] reg_offset(input int unsigned idx);
    case (idx)
      IDX_BYP:   return 8'h30;
      IDX_PORT:  return 8'h34;
      IDX_FADJ:  return 8'h38;
      IDX_END:   return 8'h40;
      IDX_COH:   return 8'h44;
      IDX_BME:   return 8'h48;
      IDX_CTRL:  return 8'h60;
      IDX_ISTAT: return 8'h64;
      IDX_IMASK: return 8'h68;
      IDX_IEN:   return 8'h6C;
      IDX_IDIS:  return 8'h70;
      IDX_SCR:   return 8'h78;
      default:   return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/usb_ctrl_csr_dec.sv
module usb_ctrl_csr_dec
  import usb_ctrl_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_REGS = NUM_REGS
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_REGS-1:0] wr_sel_o,
  output logic [N_REGS-1:0] rd_sel_o,
  output logic              miss_o
);
  logic [N_REGS-1:0] hit;

  for (genvar g = 0; g < N_REGS; g++) begin : g_hit
    // offsets are word aligned, so misaligned addresses never hit
    assign hit[g] = (addr_i == ADDR_W'(reg_offset(g)));
  end

  assign wr_sel_o = (req_i && we_i)  ? hit : '0;
  assign rd_sel_o = (req_i && !we_i) ? hit : '0;
  assign miss_o   = req_i && (hit == '0);
endmodule

// File: rtl/usb_ctrl_csr_cfg.sv
module usb_ctrl_csr_cfg
  import usb_ctrl_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_byp_i,
  input  logic              we_port_i,
  input  logic              we_fadj_i,
  input  logic              we_end_i,
  input  logic              we_coh_i,
  input  logic              we_bme_i,
  input  logic              we_ctrl_i,
  input  logic              we_scr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BYP_W-1:0]  byp_o,
  output logic [PORT_W-1:0] port_o,
  output logic [FADJ_W-1:0] fadj_o,
  output logic              endian_o,
  output logic              coh_o,
  output logic              bme_o,
  output logic              slverr_en_o,
  output logic [DATA_W-1:0] scratch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_o       <= '0;
      port_o      <= '0;
      fadj_o      <= FADJ_RST;
      endian_o    <= 1'b0;
      coh_o       <= 1'b0;
      bme_o       <= 1'b1;
      slverr_en_o <= 1'b0;
      scratch_o   <= '0;
    end else begin
      if (we_byp_i)  byp_o       <= wdata_i[BYP_W-1:0];
      if (we_port_i) port_o      <= wdata_i[PORT_W-1:0];
      if (we_fadj_i) fadj_o      <= wdata_i[FADJ_W-1:0];
      if (we_end_i)  endian_o    <= wdata_i[0];
      if (we_coh_i)  coh_o       <= wdata_i[0];
      if (we_bme_i)  bme_o       <= wdata_i[0];
      if (we_ctrl_i) slverr_en_o <= wdata_i[0];
      if (we_scr_i)  scratch_o   <= wdata_i;
    end
  end

  p_fadj_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_fadj_i |=> $stable(fadj_o));
  p_bme_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_bme_i |=> $stable(bme_o));
  p_scr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_scr_i |=> $stable(scratch_o));
  p_scr_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_scr_i |=> (scratch_o == $past(wdata_i)));
endmodule

// File: rtl/usb_ctrl_csr_irq.sv
module usb_ctrl_csr_irq
  import usb_ctrl_csr_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             stat_we_i,
  input  logic             mask_we_i,
  input  logic             en_we_i,
  input  logic             dis_we_i,
  input  logic [N_SRC-1:0] wbits_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] clr_bits;
  logic [N_SRC-1:0] status_d;
  logic [N_SRC-1:0] mask_d;

  assign clr_bits = stat_we_i ? wbits_i : '0;
  // event set wins over a same-cycle clear
  assign status_d = (status_o & ~clr_bits) | evt_i;

  always_comb begin
    mask_d = mask_o;
    if (dis_we_i)     mask_d = mask_o | wbits_i;
    else if (en_we_i) mask_d = mask_o & ~wbits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      mask_o   <= '1;
    end else begin
      status_o <= status_d;
      mask_o   <= mask_d;
    end
  end

  assign irq_o = |(status_o & ~mask_o);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i)));
  p_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && (evt_i == '0)) |=> ((status_o & $past(wbits_i)) == '0));
  p_mask_ro_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> $stable(mask_o));
  p_mask_only_via_en_dis_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_we_i && !dis_we_i) |=> $stable(mask_o));
  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_o) |-> !irq_o);
endmodule

// File: rtl/usb_ctrl_csr.sv
module usb_ctrl_csr
  import usb_ctrl_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [BYP_W-1:0]  byp_o,
  output logic [PORT_W-1:0] port_o,
  output logic [FADJ_W-1:0] frame_adj_o,
  output logic              big_endian_o,
  output logic              coherent_o,
  output logic              bus_master_en_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] wr_sel;
  logic [NUM_REGS-1:0] rd_sel;
  logic                miss;
  logic                slverr_en;
  logic [DATA_W-1:0]   scratch;
  logic [NUM_SRC-1:0]  status;
  logic [NUM_SRC-1:0]  mask;
  logic [DATA_W-1:0]   rd_word [NUM_REGS];
  logic [DATA_W-1:0]   rdata_d;
  logic                err_d;

  usb_ctrl_csr_dec #(.ADDR_W(ADDR_W), .N_REGS(NUM_REGS)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wr_sel_o (wr_sel),
    .rd_sel_o (rd_sel),
    .miss_o   (miss)
  );

  usb_ctrl_csr_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_byp_i    (wr_sel[IDX_BYP]),
    .we_port_i   (wr_sel[IDX_PORT]),
    .we_fadj_i   (wr_sel[IDX_FADJ]),
    .we_end_i    (wr_sel[IDX_END]),
    .we_coh_i    (wr_sel[IDX_COH]),
    .we_bme_i    (wr_sel[IDX_BME]),
    .we_ctrl_i   (wr_sel[IDX_CTRL]),
    .we_scr_i    (wr_sel[IDX_SCR]),
    .wdata_i     (wdata_i),
    .byp_o       (byp_o),
    .port_o      (port_o),
    .fadj_o      (frame_adj_o),
    .endian_o    (big_endian_o),
    .coh_o       (coherent_o),
    .bme_o       (bus_master_en_o),
    .slverr_en_o (slverr_en),
    .scratch_o   (scratch)
  );

  usb_ctrl_csr_irq #(.N_SRC(NUM_SRC)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .stat_we_i (wr_sel[IDX_ISTAT]),
    .mask_we_i (wr_sel[IDX_IMASK]),
    .en_we_i   (wr_sel[IDX_IEN]),
    .dis_we_i  (wr_sel[IDX_IDIS]),
    .wbits_i   (wdata_i[NUM_SRC-1:0]),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  // enable and disable words keep no state and read as zero
  always_comb begin
    rd_word = '{default: '0};
    rd_word[IDX_BYP][BYP_W-1:0]    = byp_o;
    rd_word[IDX_PORT][PORT_W-1:0]  = port_o;
    rd_word[IDX_FADJ][FADJ_W-1:0]  = frame_adj_o;
    rd_word[IDX_END][0]            = big_endian_o;
    rd_word[IDX_COH][0]            = coherent_o;
    rd_word[IDX_BME][0]            = bus_master_en_o;
    rd_word[IDX_CTRL][0]           = slverr_en;
    rd_word[IDX_ISTAT][NUM_SRC-1:0] = status;
    rd_word[IDX_IMASK][NUM_SRC-1:0] = mask;
    rd_word[IDX_SCR]               = scratch;
  end

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel[i]) rdata_d = rdata_d | rd_word[i];
    end
  end

  assign err_d = miss && slverr_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rdata_d;
      err_o   <= err_d;
    end
  end

  p_rd_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (rdata_o == '0));
  p_err_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slverr_en |=> !err_o);
  p_err_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !err_o);
endmodule

// File: tb/usb_ctrl_csr_bench.sv
`timescale 1ns/1ps
module usb_ctrl_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  evt = '0;
  logic [31:0] rdata;
  logic        err;
  logic [3:0]  byp;
  logic [4:0]  port;
  logic [5:0]  fadj;
  logic        endian, coh, bme, irq;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int   n_vec = 0;
  int   n_bad = 0;

  always #2.5 clk = ~clk;

  usb_ctrl_csr u_usb_ctrl_csr (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .err_o (err), .evt_i (evt),
    .byp_o (byp), .port_o (port), .frame_adj_o (fadj), .big_endian_o (endian),
    .coherent_o (coh), .bus_master_en_o (bme), .irq_o (irq)
  );

  // monitor: response due one cycle after each accepted request
  always @(posedge clk) begin
    if (rst_n && req) begin
      #2;
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3 response with empty scoreboard rdata=%h err=%b exp none", rdata, err);
      end else begin
        mon_e = exp_q.pop_front();
        if (rdata !== mon_e.data || err !== mon_e.err) begin
          n_bad++;
          $display("FAIL %s rdata=%h err=%b exp rdata=%h err=%b",
                   mon_e.tag, rdata, err, mon_e.data, mon_e.err);
        end
      end
    end
  end

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [31:0] exp_d, input logic exp_e, input string tag,
                     input logic [1:0] ev = 2'b00);
    exp_t e;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; evt = ev;
    e.data = exp_d; e.err = exp_e; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = 2'b00;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag,
                    input logic exp_e = 1'b0);
    bus(1'b1, a, d, 32'h0, exp_e, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp_d, input string tag,
                    input logic exp_e = 1'b0);
    bus(1'b0, a, 32'h0, exp_d, exp_e, tag);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s port act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic pulse(input logic [1:0] ev);
    @(negedge clk); evt = ev;
    @(negedge clk); evt = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports and over the bus
    chk("R1", {31'b0, irq}, 32'h0);
    chk("R1", {26'b0, fadj}, 32'h20);
    chk("R1", {31'b0, bme}, 32'h1);
    chk("R1", {28'b0, byp}, 32'h0);
    chk("R1", {27'b0, port}, 32'h0);
    chk("R1", {30'b0, endian, coh}, 32'h0);
    rd(8'h30, 32'h0, "R1"); rd(8'h34, 32'h0, "R1"); rd(8'h38, 32'h20, "R1");
    rd(8'h40, 32'h0, "R1"); rd(8'h44, 32'h0, "R1"); rd(8'h48, 32'h1, "R1");
    rd(8'h60, 32'h0, "R1"); rd(8'h64, 32'h0, "R1"); rd(8'h68, 32'h3, "R1");
    rd(8'h6C, 32'h0, "R1"); rd(8'h70, 32'h0, "R1"); rd(8'h78, 32'h0, "R11");

    // R2 field widths and output update; R3 writes return zero data
    wr(8'h30, 32'hFFFF_FFFF, "R3");
    chk("R2", {28'b0, byp}, 32'hF);
    rd(8'h30, 32'hF, "R2");
    wr(8'h34, 32'hFFFF_FFFF, "R3");
    chk("R2", {27'b0, port}, 32'h1F);
    rd(8'h34, 32'h1F, "R2");
    wr(8'h34, 32'h0000_0012, "R2");
    chk("R2", {27'b0, port}, 32'h12);
    wr(8'h38, 32'hFFFF_FFC5, "R2");
    chk("R2", {26'b0, fadj}, 32'h05);
    rd(8'h38, 32'h05, "R2");
    wr(8'h40, 32'h3, "R2");
    chk("R2", {31'b0, endian}, 32'h1);
    rd(8'h40, 32'h1, "R2");
    wr(8'h44, 32'hFFFF_FFFE, "R2");
    chk("R2", {31'b0, coh}, 32'h0);
    wr(8'h44, 32'h1, "R2");
    chk("R2", {31'b0, coh}, 32'h1);
    wr(8'h48, 32'h0, "R2");
    chk("R2", {31'b0, bme}, 32'h0);
    rd(8'h48, 32'h0, "R2");

    // R11 scratch
    wr(8'h78, 32'hDEAD_BEEF, "R11");
    rd(8'h78, 32'hDEAD_BEEF, "R11");
    wr(8'h78, 32'h1234_5678, "R11");
    rd(8'h78, 32'h1234_5678, "R11");

    // R4 mask is read-only
    wr(8'h68, 32'h0, "R4");
    rd(8'h68, 32'h3, "R4");
    chk("R4", {31'b0, irq}, 32'h0);

    // R6 and R8 events, mask, clear
    pulse(2'b01);
    rd(8'h64, 32'h1, "R6");
    chk("R8", {31'b0, irq}, 32'h0);
    wr(8'h6C, 32'h1, "R5");
    chk("R8", {31'b0, irq}, 32'h1);
    rd(8'h68, 32'h2, "R5");
    rd(8'h6C, 32'h0, "R5");
    wr(8'h64, 32'h0, "R6");
    rd(8'h64, 32'h1, "R6");
    wr(8'h64, 32'h1, "R6");
    chk("R8", {31'b0, irq}, 32'h0);
    rd(8'h64, 32'h0, "R6");
    pulse(2'b10);
    rd(8'h64, 32'h2, "R6");
    chk("R8", {31'b0, irq}, 32'h0);
    wr(8'h6C, 32'h2, "R5");
    chk("R8", {31'b0, irq}, 32'h1);
    rd(8'h68, 32'h0, "R5");
    wr(8'h70, 32'h1, "R5");
    rd(8'h68, 32'h1, "R5");
    chk("R8", {31'b0, irq}, 32'h1);
    wr(8'h70, 32'h2, "R5");
    chk("R8", {31'b0, irq}, 32'h0);
    rd(8'h68, 32'h3, "R5");
    rd(8'h70, 32'h0, "R5");
    wr(8'h6C, 32'h3, "R5");
    chk("R8", {31'b0, irq}, 32'h1);
    wr(8'h64, 32'h2, "R6");
    chk("R8", {31'b0, irq}, 32'h0);

    // R7 set beats clear in the same cycle
    bus(1'b1, 8'h64, 32'h3, 32'h0, 1'b0, "R7", 2'b01);
    rd(8'h64, 32'h1, "R7");
    chk("R7", {31'b0, irq}, 32'h1);
    wr(8'h64, 32'h1, "R6");
    chk("R6", {31'b0, irq}, 32'h0);

    // R9 unmapped and misaligned
    rd(8'h00, 32'h0, "R9");
    rd(8'h3C, 32'h0, "R9");
    rd(8'h31, 32'h0, "R9");
    wr(8'h00, 32'hFFFF_FFFF, "R9");
    wr(8'h79, 32'h0, "R9");
    wr(8'h32, 32'h0, "R9");
    rd(8'h78, 32'h1234_5678, "R9");
    chk("R9", {28'b0, byp}, 32'hF);

    // R10 slave error
    wr(8'h60, 32'h1, "R10");
    rd(8'h60, 32'h1, "R10");
    rd(8'h50, 32'h0, "R10", 1'b1);
    wr(8'h7C, 32'h5, "R10", 1'b1);
    rd(8'h35, 32'h0, "R10", 1'b1);
    rd(8'h78, 32'h1234_5678, "R10");
    wr(8'h60, 32'h0, "R10");
    rd(8'h50, 32'h0, "R10");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3 missing responses act=%0d exp=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule